// File: doc/BRIEF.md
# Converter Channel Fault and Power-Good Supervisor

This block is the clocked supervisor for one step-down converter channel. Analog comparators around the channel report raw flags: the output is under its fault floor, the output is over its crowbar ceiling, the output sits inside the power-good window, the bias supply crossed its upper or lower hysteresis point, the die crossed its hot or cool temperature point, and the soft-start ramp passed its completion level. The block deglitches these flags with counters in system clock cycles and decides what the channel does. The outputs are a power-good indication, a shutdown command, a crowbar command that holds the low-side switch on and the high-side switch off, and a one-cycle request to restart the soft-start ramp.

Overvoltage acts as a soft crowbar that releases by itself once the filtered flag clears. Undervoltage latches the channel off until enable is dropped or the supply falls below its lower point. Both responses, and power-good, are active only once soft-start has completed. Over-temperature shuts the channel down and restarts it with a fresh soft-start once the die has cooled. When the tracking strap is high, the channel acts as the follower of a tracking pair: its crowbar is disabled and its power-good stays low, because the leading channel reports for the pair.

Top module: `fault_supervisor`

## Requirements
- R1: While reset is high and on the first cycle after it, pgood_o=0, force_low_o=0, shutdown_o=1 and ss_restart_o=0.
- R2: The supply-good state is set by por_rise_i and cleared by por_fall_i, with the clear winning when both are high. While the supply is not good, shutdown_o=1 and pgood_o=0.
- R3: A change of uv_i or ov_i lasting fewer than FAULT_LEN clock cycles, or a change of pg_win_i lasting fewer than PG_LEN cycles, has no effect on any output. A change held for exactly that many cycles takes effect, with the outputs changing one cycle after the filter accepts the change.
- R4: pgood_o is 1 only while the channel runs (enable high, supply good, not hot), soft-start is complete, the filtered window flag is 1, the tracking strap is 0 and no undervoltage latch is set.
- R5: With the channel running and soft-start complete, a filtered overvoltage sets force_low_o=1 without setting shutdown_o. When the filtered flag clears, force_low_o returns to 0 by itself.
- R6: A filtered undervoltage after soft-start completion latches shutdown_o=1. The latch remains set after uv_i returns to 0 and is cleared only by en_i=0 or by a supply fall.
- R7: An undervoltage while soft-start is incomplete (ss_done_i=0) does not latch.
- R8: temp_hot_i sets shutdown_o=1 until temp_cool_i is seen. Cooling then restarts the channel with a restart request.
- R9: ss_restart_o is a single-cycle pulse, raised one cycle after the channel starts running (from enable, supply rise or cooling).
- R10: While track_i=1, pgood_o and force_low_o are 0, including during an overvoltage.
- R11: When undervoltage and overvoltage are accepted in the same cycle, the latch wins: shutdown_o=1 and force_low_o=0.
- R12: pgood_o falls on the same clock edge on which shutdown_o rises for a latched undervoltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all filters count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Channel enable |
| por_rise_i | input | 1 | Bias supply above its upper threshold |
| por_fall_i | input | 1 | Bias supply below its lower threshold |
| temp_hot_i | input | 1 | Die above the shutdown temperature |
| temp_cool_i | input | 1 | Die below the restart temperature |
| ss_done_i | input | 1 | Soft-start ramp past its completion level |
| uv_i | input | 1 | Raw undervoltage comparator flag |
| ov_i | input | 1 | Raw overvoltage comparator flag |
| pg_win_i | input | 1 | Raw flag: output inside the power-good window |
| track_i | input | 1 | Tracking strap: channel is the follower of a pair |
| pgood_o | output | 1 | Power good |
| shutdown_o | output | 1 | Channel off (disabled, supply low, hot or latched undervoltage) |
| force_low_o | output | 1 | Crowbar: low-side on, high-side blocked |
| ss_restart_o | output | 1 | One-cycle soft-start restart request |

## Verification
The undervoltage latch and the overvoltage crowbar can both fire in the same cycle. The bench raises uv_i and ov_i on the same cycle so that both filters accept on the same edge. It then requires shutdown_o to rise and force_low_o to stay low one cycle later, with both still low the cycle before. The loss of power-good and the setting of the latch also share an edge: the bench samples the cycle just before and the cycle just after and requires pgood_o and shutdown_o to swap in that single step.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  // indices into the filtered comparator flag vector
  typedef enum logic [1:0] {
    FLG_UV = 2'd0,
    FLG_OV = 2'd1,
    FLG_PG = 2'd2
  } flag_idx_e;

  localparam int NUM_FLG = 3;

  function automatic int cnt_width(input int len);
    return (len < 2) ? 1 : $clog2(len + 1);
  endfunction
endpackage

// File: rtl/fsup_deglitch.sv
module fsup_deglitch #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  import fsup_pkg::*;
  localparam int CW = cnt_width(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          differ;

  assign differ = raw_i != filt_o;

  // accept a new level only after LEN consecutive differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      filt_o <= 1'b0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      filt_o <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (raw_i == filt_o) |=> $stable(filt_o)); // R3
  AST_FILT_EARLY: assert property (@(posedge clk) disable iff (rst)
    (differ && cnt_q != LAST) |=> $stable(filt_o)); // R3
  AST_FILT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R3
endmodule

// File: rtl/fsup_hyst.sv
module fsup_hyst (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // two-threshold state: clear has priority over set
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !q_o); // R2
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> q_o); // R2
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int FAULT_LEN = 400,
  parameter int PG_LEN    = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic por_rise_i,
  input  logic por_fall_i,
  input  logic temp_hot_i,
  input  logic temp_cool_i,
  input  logic ss_done_i,
  input  logic uv_i,
  input  logic ov_i,
  input  logic pg_win_i,
  input  logic track_i,
  output logic pgood_o,
  output logic shutdown_o,
  output logic force_low_o,
  output logic ss_restart_o
);
  import fsup_pkg::*;

  logic [NUM_FLG-1:0] raw_flags;
  logic [NUM_FLG-1:0] filt_flags;
  logic supply_ok, too_hot;
  logic run, run_q, ss_ok_q;
  logic uv_lat_q, uv_next;

  assign raw_flags[FLG_UV] = uv_i;
  assign raw_flags[FLG_OV] = ov_i;
  assign raw_flags[FLG_PG] = pg_win_i;

  for (genvar gi = 0; gi < NUM_FLG; gi++) begin : g_filt
    localparam int FLEN = (gi == int'(FLG_PG)) ? PG_LEN : FAULT_LEN;
    fsup_deglitch #(.LEN(FLEN)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .raw_i (raw_flags[gi]),
      .filt_o(filt_flags[gi])
    );
  end

  fsup_hyst u_supply (
    .clk  (clk),
    .rst  (rst),
    .set_i(por_rise_i),
    .clr_i(por_fall_i),
    .q_o  (supply_ok)
  );

  fsup_hyst u_thermal (
    .clk  (clk),
    .rst  (rst),
    .set_i(temp_hot_i),
    .clr_i(temp_cool_i),
    .q_o  (too_hot)
  );

  assign run = en_i && supply_ok && !too_hot;

  // undervoltage latch: set after soft-start, cleared by enable or supply cycling
  always_comb begin
    if (!en_i || !supply_ok) uv_next = 1'b0;
    else                     uv_next = uv_lat_q || (run && ss_ok_q && filt_flags[FLG_UV]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q        <= 1'b0;
      ss_ok_q      <= 1'b0;
      uv_lat_q     <= 1'b0;
      pgood_o      <= 1'b0;
      shutdown_o   <= 1'b1;
      force_low_o  <= 1'b0;
      ss_restart_o <= 1'b0;
    end else begin
      run_q        <= run;
      ss_ok_q      <= run && ss_done_i;
      uv_lat_q     <= uv_next;
      shutdown_o   <= !run || uv_next;
      pgood_o      <= run && ss_ok_q && filt_flags[FLG_PG] && !track_i && !uv_next;
      force_low_o  <= run && ss_ok_q && filt_flags[FLG_OV] && !track_i && !uv_next;
      ss_restart_o <= run && !run_q;
    end
  end

  AST_PG_OFF_IN_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
    pgood_o |-> !shutdown_o); // R4
  AST_CROWBAR_NOT_OFF: assert property (@(posedge clk) disable iff (rst)
    force_low_o |-> !shutdown_o); // R11
  AST_TRACK_QUIET: assert property (@(posedge clk) disable iff (rst)
    track_i |=> (!pgood_o && !force_low_o)); // R10
  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (rst)
    ss_restart_o |=> !ss_restart_o); // R9
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (uv_lat_q && en_i && supply_ok) |=> (uv_lat_q && shutdown_o)); // R6
  AST_NO_LATCH_PRE_SS: assert property (@(posedge clk) disable iff (rst)
    (!uv_lat_q && !ss_ok_q) |=> !uv_lat_q); // R7
  AST_SUPPLY_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (shutdown_o && !pgood_o)); // R2
  AST_HOT_OFF: assert property (@(posedge clk) disable iff (rst)
    too_hot |=> shutdown_o); // R8
endmodule

// File: tb/fault_supervisor_tb.sv
module fault_supervisor_tb;
  localparam int LF = 4;
  localparam int LP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 0, por_rise_i = 0, por_fall_i = 0, temp_hot_i = 0, temp_cool_i = 0;
  logic ss_done_i = 0, uv_i = 0, ov_i = 0, pg_win_i = 0, track_i = 0;
  logic pgood_o, shutdown_o, force_low_o, ss_restart_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fault_supervisor #(.FAULT_LEN(LF), .PG_LEN(LP)) u_dut (
    .clk(clk), .rst(rst), .en_i(en_i), .por_rise_i(por_rise_i),
    .por_fall_i(por_fall_i), .temp_hot_i(temp_hot_i), .temp_cool_i(temp_cool_i),
    .ss_done_i(ss_done_i), .uv_i(uv_i), .ov_i(ov_i), .pg_win_i(pg_win_i),
    .track_i(track_i), .pgood_o(pgood_o), .shutdown_o(shutdown_o),
    .force_low_o(force_low_o), .ss_restart_o(ss_restart_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    tick(100000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    tick(3);
    // R1 reset values
    chk("R1", "pgood", pgood_o, 1'b0);
    chk("R1", "shutdown", shutdown_o, 1'b1);
    chk("R1", "force_low", force_low_o, 1'b0);
    rst = 1'b0;
    tick(1);
    chk("R1", "restart after reset", ss_restart_o, 1'b0);
    chk("R1", "shutdown after reset", shutdown_o, 1'b1);

    // R9 start: enable then supply rise
    en_i = 1; pg_win_i = 1;
    tick(2);
    chk("R2", "no supply shutdown", shutdown_o, 1'b1);
    por_rise_i = 1;
    tick(1); por_rise_i = 0;
    chk("R9", "restart not yet", ss_restart_o, 1'b0);
    tick(1);
    chk("R9", "restart pulse", ss_restart_o, 1'b1);
    chk("R2", "running after rise", shutdown_o, 1'b0);
    tick(1);
    chk("R9", "restart single", ss_restart_o, 1'b0);

    // R7 undervoltage before soft-start completes
    uv_i = 1;
    tick(3 * LF);
    chk("R7", "no latch pre ss", shutdown_o, 1'b0);
    chk("R4", "no pgood pre ss", pgood_o, 1'b0);
    uv_i = 0;
    tick(LF + 2);
    ss_done_i = 1;
    tick(LP + 4);
    chk("R4", "pgood up", pgood_o, 1'b1);

    // R3 sweep of short overvoltage glitches
    for (int g = 1; g < LF; g++) begin
      ov_i = 1; tick(g); ov_i = 0;
      for (int w = 0; w < LF + 2; w++) begin
        chk("R3", "ov glitch ignored", force_low_o, 1'b0);
        tick(1);
      end
    end
    // R3 sweep of short window drops
    for (int g = 1; g < LP; g++) begin
      pg_win_i = 0; tick(g); pg_win_i = 1;
      for (int w = 0; w < LP + 2; w++) begin
        chk("R3", "pg glitch ignored", pgood_o, 1'b1);
        tick(1);
      end
    end
    // R3 window drop of exactly LP cycles
    pg_win_i = 0;
    tick(LP);
    chk("R3", "pg before accept", pgood_o, 1'b1);
    tick(1);
    chk("R3", "pg dropped", pgood_o, 1'b0);
    pg_win_i = 1;
    tick(LP + 1);
    chk("R4", "pg back", pgood_o, 1'b1);

    // R5 crowbar sets and releases
    ov_i = 1;
    tick(LF);
    chk("R3", "ov before accept", force_low_o, 1'b0);
    tick(1);
    chk("R5", "crowbar on", force_low_o, 1'b1);
    chk("R5", "no shutdown in crowbar", shutdown_o, 1'b0);
    ov_i = 0;
    tick(LF + 1);
    chk("R5", "crowbar released", force_low_o, 1'b0);

    // R10 tracking strap
    track_i = 1; ov_i = 1;
    tick(LF + 3);
    chk("R10", "track pgood", pgood_o, 1'b0);
    chk("R10", "track crowbar", force_low_o, 1'b0);
    track_i = 0; ov_i = 0;
    tick(LF + 3);
    chk("R4", "pgood after track", pgood_o, 1'b1);

    // R6 R12 undervoltage latch
    uv_i = 1;
    tick(LF);
    chk("R12", "pgood before latch", pgood_o, 1'b1);
    chk("R12", "shutdown before latch", shutdown_o, 1'b0);
    tick(1);
    chk("R12", "pgood at latch", pgood_o, 1'b0);
    chk("R6", "latched", shutdown_o, 1'b1);
    uv_i = 0;
    tick(LF + 10);
    chk("R6", "latch holds", shutdown_o, 1'b1);
    en_i = 0; tick(2); en_i = 1;
    tick(1);
    chk("R6", "cleared by enable", shutdown_o, 1'b0);
    chk("R9", "restart after enable", ss_restart_o, 1'b1);
    tick(LP + 3);
    chk("R4", "pgood after clear", pgood_o, 1'b1);

    // R11 simultaneous undervoltage and overvoltage
    uv_i = 1; ov_i = 1;
    tick(LF);
    chk("R11", "both pre shutdown", shutdown_o, 1'b0);
    chk("R11", "both pre crowbar", force_low_o, 1'b0);
    tick(1);
    chk("R11", "latch wins", shutdown_o, 1'b1);
    chk("R11", "crowbar suppressed", force_low_o, 1'b0);
    uv_i = 0; ov_i = 0;
    tick(LF + 2);

    // R2 supply fall clears latch, fall beats rise
    por_fall_i = 1; por_rise_i = 1;
    tick(2);
    por_fall_i = 0; por_rise_i = 0;
    chk("R2", "fall wins", shutdown_o, 1'b1);
    por_rise_i = 1; tick(1); por_rise_i = 0;
    tick(1);
    chk("R2", "latch cleared by supply", shutdown_o, 1'b0);
    chk("R9", "restart after supply", ss_restart_o, 1'b1);
    tick(LP + 3);

    // R8 thermal shutdown and recovery
    temp_hot_i = 1; tick(1); temp_hot_i = 0;
    tick(1);
    chk("R8", "hot shutdown", shutdown_o, 1'b1);
    chk("R8", "hot pgood", pgood_o, 1'b0);
    tick(5);
    chk("R8", "stays hot", shutdown_o, 1'b1);
    temp_cool_i = 1; tick(1); temp_cool_i = 0;
    tick(1);
    chk("R8", "cooled run", shutdown_o, 1'b0);
    chk("R8", "cool restart", ss_restart_o, 1'b1);

    done = 1;
    summary();
  end
endmodule